// File: doc/BRIEF.md
# Bit Test and Modify Unit

This execution unit picks one bit out of a register operand, using a second operand as the bit position. It returns the old value of that bit as a carry flag. Depending on the operation code it then writes the operand back unchanged, with the bit forced to 1, with the bit forced to 0, or with the bit inverted. The operand may be 16 or 32 bits wide. The bit position comes either from a full-width register offset or from an 8-bit immediate. In both cases it wraps modulo the operand width, so a position past the top of the operand folds back into it.

The issuing pipeline presents the operands and raises a valid strobe for one cycle. On the next clock edge the unit registers the updated operand and the carry, and raises a done pulse for one cycle. When no strobe arrives, the registered results hold their values. Memory-resident bit strings are not handled; both operands are registers.

Top module: `bit_test_modify`

## Requirements
- R1: A synchronous active-high reset clears `resultOut`, `carryOut` and `doneOut` to 0.
- R2: `doneOut` is 1 in the cycle after a cycle in which `inValid` was 1, and 0 after a cycle in which `inValid` was 0.
- R3: `carryOut` takes the pre-operation value of the selected bit of `baseIn`. The bit index is the low 5 bits of the offset when `wide`=1 (32-bit operand) and the low 4 bits when `wide`=0 (16-bit operand). Example: 16-bit base 0x081F with offset 33 selects bit 1 and gives carry 1.
- R4: `useImm`=1 takes the offset from the 8-bit `offImm`; `useImm`=0 takes it from the 32-bit `offReg`. The unused offset input has no effect.
- R5: `opSel`=0 (test) returns `baseIn` unchanged on `resultOut`.
- R6: `opSel`=1 (set) returns `baseIn` with the selected bit forced to 1.
- R7: `opSel`=2 (clear) returns `baseIn` with the selected bit forced to 0.
- R8: `opSel`=3 (invert) returns `baseIn` with the selected bit inverted.
- R9: Every bit other than the selected one passes unchanged to `resultOut`. This includes bits 31:16 when the operand is 16 bits wide.
- R10: While `inValid` is 0, `resultOut` and `carryOut` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation strobe |
| opSel | input | 2 | 0 test, 1 set, 2 clear, 3 invert |
| wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| useImm | input | 1 | Selects the immediate offset |
| baseIn | input | 32 | Base operand |
| offReg | input | 32 | Register bit offset |
| offImm | input | 8 | Immediate bit offset |
| resultOut | output | 32 | Updated base operand |
| carryOut | output | 1 | Old value of the selected bit |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle: the timing of the done pulse, holding while idle, the carry capture, the forced value of the selected bit for each operation, and that no other bit moves. These checks are made against the decoded position inside the unit. The position wrap for each width, the choice of offset source, and the known worked example can only be shown by the bench's sweeps. The bench compares against positions it derives arithmetically from the raw offsets, which the assertions never see.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [1:0] {
    OP_TEST  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } btmOp_e;

  typedef struct packed {
    logic capture;
    logic setBit;
    logic clearBit;
    logic flipBit;
  } btmCtrl_t;

endpackage

// File: rtl/btm_control.sv
module btm_control
  import btm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] opSel,
  output btmCtrl_t   ctrl,
  output logic       doneOut
);

  btmOp_e opCode;

  always_comb begin
    opCode        = btmOp_e'(opSel);
    ctrl          = '0;
    ctrl.capture  = inValid;
    ctrl.setBit   = inValid && (opCode == OP_SET);
    ctrl.clearBit = inValid && (opCode == OP_CLEAR);
    ctrl.flipBit  = inValid && (opCode == OP_FLIP);
  end

  always_ff @(posedge clk) begin
    if (rst) doneOut <= 1'b0;
    else     doneOut <= inValid;
  end

  // Done pulse follows every accepted strobe.
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> doneOut);

  // No done without a strobe.
  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !doneOut);

  // At most one modify strobe.
  assert_one_modify_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.setBit, ctrl.clearBit, ctrl.flipBit}));

endmodule

// File: rtl/btm_datapath.sv
module btm_datapath
  import btm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  btmCtrl_t          ctrl,
  input  logic              wide,
  input  logic              useImm,
  input  logic [DATA_W-1:0] baseIn,
  input  logic [DATA_W-1:0] offReg,
  input  logic [IMM_W-1:0]  offImm,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);

  localparam int IDX_W    = $clog2(DATA_W);
  localparam int NARROW_W = IDX_W - 1;

  logic [DATA_W-1:0] offSel;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] bitMask;
  logic              selBit;
  logic [DATA_W-1:0] nextVal;

  assign offSel = useImm ? {{(DATA_W-IMM_W){1'b0}}, offImm} : offReg;
  assign bitIdx = wide ? offSel[IDX_W-1:0] : {1'b0, offSel[NARROW_W-1:0]};

  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign bitMask[i] = (bitIdx == IDX_W'(i));
  end

  assign selBit = |(baseIn & bitMask);

  always_comb begin
    nextVal = baseIn;
    if (ctrl.flipBit)       nextVal = baseIn ^ bitMask;
    else if (ctrl.setBit)   nextVal = baseIn | bitMask;
    else if (ctrl.clearBit) nextVal = baseIn & ~bitMask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultOut <= '0;
      carryOut  <= 1'b0;
    end else if (ctrl.capture) begin
      resultOut <= nextVal;
      carryOut  <= selBit;
    end
  end

  assert_onehot_mask_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(bitMask) == 1);

  assert_carry_old_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> carryOut == ($past(baseIn & bitMask) != '0));

  assert_test_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && !ctrl.setBit && !ctrl.clearBit && !ctrl.flipBit)
      |=> resultOut == $past(baseIn));

  assert_set_forces_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.setBit |=> (resultOut & $past(bitMask)) != '0);

  assert_clear_forces_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.clearBit |=> (resultOut & $past(bitMask)) == '0);

  assert_flip_inverts_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.flipBit |=> ((resultOut & $past(bitMask)) != '0) != $past(selBit));

  assert_others_unchanged_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> ((resultOut ^ $past(baseIn)) & ~$past(bitMask)) == '0);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> $stable(resultOut) && $stable(carryOut));

endmodule

// File: rtl/bit_test_modify.sv
module bit_test_modify
  import btm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic              wide,
  input  logic              useImm,
  input  logic [DATA_W-1:0] baseIn,
  input  logic [DATA_W-1:0] offReg,
  input  logic [IMM_W-1:0]  offImm,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut,
  output logic              doneOut
);

  btmCtrl_t ctrl;

  btm_control u_control (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opSel   (opSel),
    .ctrl    (ctrl),
    .doneOut (doneOut)
  );

  btm_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .wide      (wide),
    .useImm    (useImm),
    .baseIn    (baseIn),
    .offReg    (offReg),
    .offImm    (offImm),
    .resultOut (resultOut),
    .carryOut  (carryOut)
  );

  // Reset leaves outputs at zero.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (resultOut == '0) && !carryOut && !doneOut);

endmodule

// File: tb/bit_test_modify_test.sv
module bit_test_modify_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic        wide = 1'b1;
  logic        useImm = 1'b0;
  logic [31:0] baseIn = '0;
  logic [31:0] offReg = '0;
  logic [7:0]  offImm = '0;
  logic [31:0] resultOut;
  logic        carryOut;
  logic        doneOut;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_test_modify uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel), .wide(wide),
    .useImm(useImm), .baseIn(baseIn), .offReg(offReg), .offImm(offImm),
    .resultOut(resultOut), .carryOut(carryOut), .doneOut(doneOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issues one operation and checks the registered outputs.
  task automatic doOp(input logic w, input logic [1:0] op, input logic imm,
                      input logic [31:0] base, input logic [7:0] off);
    int idx;
    logic oldBit;
    logic [31:0] expRes;
    @(negedge clk);
    inValid = 1'b1; opSel = op; wide = w; useImm = imm; baseIn = base;
    if (imm) begin
      offImm = off; offReg = 32'h3C5A_7E00 | 32'(~off);
    end else begin
      offReg = 32'h7F3A_6C00 | 32'(off); offImm = ~off;
    end
    idx = w ? (int'(off) % 32) : (int'(off) % 16);
    oldBit = base[idx];
    expRes = base;
    case (op)
      2'd1: expRes[idx] = 1'b1;
      2'd2: expRes[idx] = 1'b0;
      2'd3: expRes[idx] = ~oldBit;
      default: ;
    endcase
    @(negedge clk);
    inValid = 1'b0;
    check("R3/R4 carry", {31'd0, carryOut}, {31'd0, oldBit});
    check(op == 0 ? "R5/R9 result" : op == 1 ? "R6/R9 result" :
          op == 2 ? "R7/R9 result" : "R8/R9 result", resultOut, expRes);
    check("R2 done", {31'd0, doneOut}, 32'd1);
  endtask

  initial begin
    logic [31:0] bases [4];
    logic [31:0] keepRes;
    logic keepC;
    bases[0] = 32'h0000_0000; bases[1] = 32'hFFFF_FFFF;
    bases[2] = 32'hA5C3_081F; bases[3] = 32'h5A3C_F7E0;

    repeat (3) @(negedge clk);
    check("R1 result", resultOut, 32'd0);
    check("R1 carry", {31'd0, carryOut}, 32'd0);
    check("R1 done", {31'd0, doneOut}, 32'd0);
    rst = 1'b0;

    // R3 worked example: 16-bit 0x081F, offset 33 -> bit 1, carry 1.
    doOp(1'b0, 2'd0, 1'b0, 32'h0000_081F, 8'd33);
    doOp(1'b0, 2'd3, 1'b1, 32'h0000_081F, 8'd33);

    for (int w = 0; w < 2; w++)
      for (int op = 0; op < 4; op++)
        for (int src = 0; src < 2; src++)
          for (int b = 0; b < 4; b++)
            for (int off = 0; off < 64; off++)
              doOp(w[0], op[1:0], src[0], bases[b], off[7:0]);

    // Immediate offsets past 63 still wrap (R3, R4).
    for (int off = 64; off < 256; off += 37)
      doOp(1'b1, 2'd3, 1'b1, 32'h1234_5678, off[7:0]);

    // R10/R2: idle inputs change nothing.
    keepRes = resultOut; keepC = carryOut;
    @(negedge clk);
    baseIn = 32'hDEAD_BEEF; offReg = 32'd7; offImm = 8'd3; opSel = 2'd3;
    repeat (3) @(negedge clk);
    check("R10 hold result", resultOut, keepRes);
    check("R10 hold carry", {31'd0, carryOut}, {31'd0, keepC});
    check("R2 done low", {31'd0, doneOut}, 32'd0);

    // R1: reset after activity.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 result after reset", resultOut, 32'd0);
    check("R1 carry after reset", {31'd0, carryOut}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule